// File: doc/BRIEF.md
# Centre-Aligned PWM Timer

This block is an 8-bit timer that counts up from zero to 255 and then back down to zero. It drives one waveform output that is symmetric about the bottom of the count. The output changes state when the count passes a programmable threshold, once on the rising slope and once on the falling slope. Because the waveform is centred, its edges keep their phase when the duty changes, which is why this kind of timer is used for motor and power stages. A prescaler derives the timer tick from the system clock.

Software reaches the block through a write strobe with an address and write data, and through a separate read address that drives a combinational read-data bus. A new threshold goes into a holding register first. The threshold that is in effect takes the new value only when the count reaches its peak, so a period always starts and ends with the same threshold. Two sticky flags record the bottom of the count and every threshold match. Each flag is cleared by writing a one to its bit.

Top module: `pc_pwm_timer`

## Requirements
- R1: After reset the count reads 0, `pwm_o`, `ovf_flag_o` and `cmp_flag_o` are 0, and the control and threshold registers read 0, so the tick is stopped and the output is disconnected.
- R2: On each tick the count moves by one: up from 0 to 255, then down to 0, then up again. The peak and the bottom each last exactly one tick, so one period is 510 ticks.
- R3: Control bits [2:0] select the tick. Codes 1, 2, 3, 4 and 5 divide the clock by 1, 8, 64, 256 and 1024. Codes 0, 6 and 7 stop the tick, and the count and `pwm_o` then hold their values.
- R4: In output mode 2 (non-inverted, control bits [5:4]), the output goes low when the rising count reaches the threshold and goes high when the falling count reaches it. A threshold of 0 keeps the output low and 255 keeps it high, so each period holds the output high for 2 × threshold ticks.
- R5: Output mode 3 gives the exact complement of mode 2, so each period holds the output low for 2 × threshold ticks.
- R6: Output modes 0 and 1 force `pwm_o` to 0.
- R7: A write to address 1 updates only the holding register, and address 1 reads it back. The threshold in effect loads from it in the tick where the count becomes 255, and that new value already applies at the peak.
- R8: The overflow flag (flag bit 0) is set in the tick where the count becomes 0 and stays set until it is cleared.
- R9: The compare flag (flag bit 1) is set in any tick where the new count equals the threshold in effect, on either slope, and stays set until it is cleared.
- R10: A write to address 3 clears each flag whose data bit is 1 and leaves the others alone. If a flag is set and cleared in the same cycle, it ends up set.
- R11: Address 0 reads back the control fields and address 2 reads the count. Writes to address 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 threshold, 2 count, 3 flags |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | 8 | Combinational read data |
| pwm_o | output | 1 | Waveform output |
| ovf_flag_o | output | 1 | Sticky flag, set at the bottom of the count |
| cmp_flag_o | output | 1 | Sticky flag, set on a threshold match |

## Verification
Every result of a tick is registered together with the count. The new count, the waveform level, the threshold load and both flags all appear in the same cycle, one clock edge after the tick. A control or threshold write takes effect at the edge where it is strobed, and the tick it enables comes one edge later. The bench drives inputs on the falling edge and samples on the next falling edge. Against its own triangle model it compares each sample with the previous one, and model updates caused by a write are made just after the rising edge that performs the write. Period-level duty counts start on the sample where the count first reads 255, which is the cycle the new threshold takes effect.

// File: rtl/pc_pwm_pkg.sv
package pc_pwm_pkg;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned SEL_LSB  = 0;
  localparam int unsigned MODE_LSB = 4;
  localparam int unsigned OVF_BIT  = 0;
  localparam int unsigned CMP_BIT  = 1;
  localparam int unsigned NUM_DIV  = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_CMP  = 2'd1,
    REG_CNT  = 2'd2,
    REG_FLAG = 2'd3
  } reg_addr_e;

  // log2 of the divide ratio for select code idx+1
  function automatic int unsigned div_shift(input int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      2:       return 6;
      3:       return 8;
      default: return 10;
    endcase
  endfunction

  localparam int unsigned DIV_W = div_shift(NUM_DIV - 1);
endpackage

// File: rtl/pc_pwm_prescaler.sv
module pc_pwm_prescaler
  import pc_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [DIV_W-1:0]   div_q;
  logic [NUM_DIV-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
    localparam int unsigned SH = div_shift(g);
    if (SH == 0) begin : g_full
      assign tap[g] = 1'b1;
    end else begin : g_div
      assign tap[g] = &div_q[SH-1:0];
    end
  end

  always_comb begin
    tick_o = 1'b0;
    if (sel_i >= SEL_W'(1) && sel_i <= SEL_W'(NUM_DIV))
      tick_o = tap[SEL_W'(sel_i - SEL_W'(1))];
  end
endmodule

// File: rtl/pc_pwm_counter.sv
module pc_pwm_counter
  import pc_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic             up_nx_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  always_comb begin
    cnt_nx_o = cnt_q;
    up_nx_o  = up_q;
    if (tick_i) begin
      if (up_q) begin
        cnt_nx_o = cnt_q + 1'b1;
        if (cnt_q == TOP - 1'b1) up_nx_o = 1'b0;
      end else begin
        cnt_nx_o = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) up_nx_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_nx_o;
      up_q  <= up_nx_o;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pc_pwm_compare.sv
module pc_pwm_compare
  import pc_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_nx_i,
  input  logic             up_nx_i,
  input  logic [CNT_W-1:0] buf_i,
  output logic [CNT_W-1:0] ocr_o,
  output logic             wave_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] ocr_q;
  logic             wave_q;
  logic             at_top;
  logic [CNT_W-1:0] ref_val;

  assign at_top  = tick_i && (cnt_nx_i == TOP);
  // the fresh threshold is already in force at the peak
  assign ref_val = at_top ? buf_i : ocr_q;
  assign hit_o   = tick_i && (cnt_nx_i == ref_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      if (at_top) begin
        ocr_q  <= buf_i;
        // resolve level at the peak so a threshold change never glitches
        wave_q <= (buf_i == TOP);
      end else if (hit_o) begin
        wave_q <= ~up_nx_i;
      end
    end
  end

  assign ocr_o  = ocr_q;
  assign wave_o = wave_q;
endmodule

// File: rtl/pc_pwm_timer.sv
module pc_pwm_timer
  import pc_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              pwm_o,
  output logic              ovf_flag_o,
  output logic              cmp_flag_o
);
  logic [SEL_W-1:0]  sel_q;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cmp_buf_q;
  logic              ovf_q, cmpf_q;

  logic              tick;
  logic [CNT_W-1:0]  cnt_w, cnt_nx_w, ocr_w;
  logic              up_nx_w, wave_w, hit_w;
  logic              wr_ctrl, wr_cmp, wr_flag;
  logic              ovf_set, ovf_clr, cmp_clr;

  pc_pwm_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  pc_pwm_counter u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .cnt_o    (cnt_w),
    .cnt_nx_o (cnt_nx_w),
    .up_nx_o  (up_nx_w)
  );

  pc_pwm_compare u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .cnt_nx_i (cnt_nx_w),
    .up_nx_i  (up_nx_w),
    .buf_i    (cmp_buf_q),
    .ocr_o    (ocr_w),
    .wave_o   (wave_w),
    .hit_o    (hit_w)
  );

  assign wr_ctrl = wr_en_i && (wr_addr_i == REG_CTRL);
  assign wr_cmp  = wr_en_i && (wr_addr_i == REG_CMP);
  assign wr_flag = wr_en_i && (wr_addr_i == REG_FLAG);
  assign ovf_set = tick && (cnt_nx_w == '0);
  assign ovf_clr = wr_flag && wr_data_i[OVF_BIT];
  assign cmp_clr = wr_flag && wr_data_i[CMP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      mode_q    <= '0;
      cmp_buf_q <= '0;
      ovf_q     <= 1'b0;
      cmpf_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sel_q  <= wr_data_i[SEL_LSB +: SEL_W];
        mode_q <= wr_data_i[MODE_LSB +: MODE_W];
      end
      if (wr_cmp) cmp_buf_q <= wr_data_i;
      // set beats clear
      ovf_q  <= ovf_set | (ovf_q & ~ovf_clr);
      cmpf_q <= hit_w   | (cmpf_q & ~cmp_clr);
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      REG_CTRL: begin
        rd_data_o[SEL_LSB +: SEL_W]   = sel_q;
        rd_data_o[MODE_LSB +: MODE_W] = mode_q;
      end
      REG_CMP:  rd_data_o = cmp_buf_q;
      REG_CNT:  rd_data_o = cnt_w;
      default: begin
        rd_data_o[OVF_BIT] = ovf_q;
        rd_data_o[CMP_BIT] = cmpf_q;
      end
    endcase
  end

  assign pwm_o      = mode_q[1] & (wave_w ^ mode_q[0]);
  assign ovf_flag_o = ovf_q;
  assign cmp_flag_o = cmpf_q;
endmodule

// File: rtl/pc_pwm_timer_chk.sv
module pc_pwm_timer_chk
  import pc_pwm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [CNT_W-1:0]  ocr_w,
  input logic [SEL_W-1:0]  sel_q,
  input logic [MODE_W-1:0] mode_q,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic              pwm_o,
  input logic              ovf_flag_o,
  input logic              cmp_flag_o
);
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w != $past(cnt_w)) |->
      (cnt_w == $past(cnt_w) + 1'b1 || cnt_w == $past(cnt_w) - 1'b1));

  // R2
  peak_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_w) == '1 && cnt_w != '1) |-> (cnt_w == CNT_W'(254)));

  // R3
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == '0 || sel_q > SEL_W'(NUM_DIV)) |=> ($stable(cnt_w) && $stable(pwm_o)));

  // R6
  mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1] == 1'b0) |-> !pwm_o);

  // R7
  ocr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ocr_w) |-> (cnt_w == '1));

  // R8
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_w) == CNT_W'(1) && cnt_w == '0) |-> ovf_flag_o);

  // R10
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !(wr_en_i && wr_addr_i == REG_FLAG && wr_data_i[OVF_BIT])) |=> ovf_flag_o);

  // R10
  cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_flag_o && !(wr_en_i && wr_addr_i == REG_FLAG && wr_data_i[CMP_BIT])) |=> cmp_flag_o);
endmodule

bind pc_pwm_timer pc_pwm_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_w      (cnt_w),
  .ocr_w      (ocr_w),
  .sel_q      (sel_q),
  .mode_q     (mode_q),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .pwm_o      (pwm_o),
  .ovf_flag_o (ovf_flag_o),
  .cmp_flag_o (cmp_flag_o)
);

// File: tb/pc_pwm_timer_test.sv
`timescale 1ns/1ps
module pc_pwm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = 2'd2;
  logic [7:0] rd_data;
  logic       pwm, ovf_flag, cmp_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  bit         mon_en = 0;
  bit         prev_v = 0;
  bit         m_up = 1;
  logic [7:0] prev = '0;
  logic [7:0] m_buf = '0;
  logic [7:0] m_act = '0;
  logic [1:0] m_mode = '0;
  logic [7:0] c, exp_c;
  bit         w, e_pwm;

  always #4 clk = ~clk;

  pc_pwm_timer uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .pwm_o      (pwm),
    .ovf_flag_o (ovf_flag),
    .cmp_flag_o (cmp_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    if (a == 2'd1) m_buf = d;
    if (a == 2'd0) m_mode = d[5:4];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // wait for a sample equal to v reached on the given slope
  task automatic wait_val(input logic [7:0] v, input bit dn);
    logic [7:0] last;
    last = rd_data;
    forever begin
      @(negedge clk);
      if (rd_data == v && ((dn && rd_data < last) || (!dn && rd_data > last))) break;
      last = rd_data;
    end
  endtask

  // per-cycle model of the triangle, the waveform and the flags
  always @(negedge clk) begin
    if (mon_en) begin
      c = rd_data;
      if (prev_v) begin
        exp_c = m_up ? prev + 8'd1 : prev - 8'd1;
        chk(c == exp_c, "R2", c, exp_c);
        if (c == 8'hff) m_act = m_buf;  // R7 load at peak
        w = (c < m_act) || (c == m_act && c != 8'd0 && (c == 8'hff || c < prev));
        e_pwm = (m_mode == 2'd2) ? w : (m_mode == 2'd3) ? !w : 1'b0;
        if (m_mode == 2'd2)      chk(pwm == e_pwm, "R4", pwm, e_pwm);
        else if (m_mode == 2'd3) chk(pwm == e_pwm, "R5", pwm, e_pwm);
        else                     chk(pwm == e_pwm, "R6", pwm, e_pwm);
        if (c == 8'd0)  chk(ovf_flag == 1'b1, "R8", ovf_flag, 1);
        if (c == m_act) chk(cmp_flag == 1'b1, "R9", cmp_flag, 1);
        if (c == 8'hff)     m_up = 1'b0;
        else if (c == 8'd0) m_up = 1'b1;
      end
      prev = c;
      prev_v = 1'b1;
    end
  end

  task automatic duty(input logic [7:0] thr, input bit inv, input string req);
    int hi;
    hi = 0;
    wait_val(8'hff, 1'b0);
    for (int i = 0; i < 510; i++) begin
      if (i != 0) @(negedge clk);
      if (pwm) hi++;
    end
    if (inv) chk(510 - hi == 2 * thr, req, 510 - hi, 2 * thr);
    else     chk(hi == 2 * thr, req, hi, 2 * thr);
  endtask

  task automatic set_thr(input logic [7:0] thr);
    wait_val(8'd100, 1'b0);
    wr(2'd1, thr);
  endtask

  task automatic measure_div(input logic [2:0] code, input int n);
    logic [7:0] last;
    int cnt;
    wr(2'd0, {2'b00, 2'd2, 1'b0, code});
    last = rd_data;
    do @(negedge clk); while (rd_data == last);
    last = rd_data;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (rd_data == last);
    chk(cnt == n, "R3", cnt, n);
  endtask

  task automatic stop_hold(input logic [2:0] code);
    logic [7:0] c0;
    logic       p0;
    bit         ok;
    wr(2'd0, {2'b00, 2'd2, 1'b0, code});
    c0 = rd_data; p0 = pwm; ok = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (rd_data != c0 || pwm != p0) ok = 1'b0;
    end
    chk(ok, "R3", rd_data, c0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] thr_list [12];
    thr_list = '{8'd20, 8'd0, 8'd1, 8'd2, 8'd64, 8'd127, 8'd128, 8'd200,
                 8'd253, 8'd254, 8'd255, 8'd37};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rd_data == 8'd0, "R1", rd_data, 0);
    chk(pwm == 1'b0, "R1", pwm, 0);
    chk(ovf_flag == 1'b0 && cmp_flag == 1'b0, "R1", {ovf_flag, cmp_flag}, 0);
    rd_addr = 2'd1; #1 chk(rd_data == 8'd0, "R1", rd_data, 0);
    rd_addr = 2'd0; #1 chk(rd_data == 8'd0, "R1", rd_data, 0);

    // R11 map, R7 holding register readback
    wr(2'd2, 8'h55);
    rd_addr = 2'd2; #1 chk(rd_data == 8'd0, "R11", rd_data, 0);
    wr(2'd0, 8'h20);
    rd_addr = 2'd0; #1 chk(rd_data == 8'h20, "R11", rd_data, 8'h20);
    wr(2'd1, 8'hff);
    rd_addr = 2'd1; #1 chk(rd_data == 8'hff, "R7", rd_data, 8'hff);
    chk(pwm == 1'b0, "R7", pwm, 0);
    rd_addr = 2'd2;

    // start: mode 2, divide by 1
    wr(2'd0, 8'h21);
    mon_en = 1'b1;

    duty(8'hff, 1'b0, "R4");
    // threshold change while old value holds output high: no early drop
    set_thr(8'd20);
    @(negedge clk);
    chk(pwm == 1'b1, "R7", pwm, 1);
    for (int i = 0; i < 12; i++) begin
      if (i != 0) set_thr(thr_list[i]);
      duty(thr_list[i], 1'b0, "R4");
    end

    // R5 inverted mode
    wr(2'd0, 8'h31);
    foreach (thr_list[i]) begin
      if (i == 1 || i == 6 || i == 10) begin
        set_thr(thr_list[i]);
        duty(thr_list[i], 1'b1, "R5");
      end
    end

    // R6 disconnected modes
    wr(2'd0, 8'h11);
    duty(8'd0, 1'b0, "R6");
    wr(2'd0, 8'h01);
    duty(8'd0, 1'b0, "R6");
    wr(2'd0, 8'h21);

    // R10 write-one-to-clear, per bit
    set_thr(8'd128);
    wait_val(8'd50, 1'b0);
    wr(2'd3, 8'h01);
    chk(ovf_flag == 1'b0, "R10", ovf_flag, 0);
    chk(cmp_flag == 1'b1, "R10", cmp_flag, 1);
    wr(2'd3, 8'h02);
    chk(cmp_flag == 1'b0, "R10", cmp_flag, 0);
    // R8 sticky: stays clear until the bottom, then set
    wait_val(8'd10, 1'b1);
    chk(ovf_flag == 1'b0, "R8", ovf_flag, 0);
    // R10 set wins over a clear in the same cycle
    wait_val(8'd2, 1'b1);
    wr(2'd3, 8'h01);
    chk(ovf_flag == 1'b1, "R10", ovf_flag, 1);
    chk(rd_data == 8'd0, "R8", rd_data, 0);

    // R3 prescale ratios and stop codes
    @(negedge clk);
    mon_en = 1'b0;
    measure_div(3'd1, 1);
    measure_div(3'd2, 8);
    measure_div(3'd3, 64);
    measure_div(3'd4, 256);
    measure_div(3'd5, 1024);
    stop_hold(3'd0);
    stop_hold(3'd6);
    stop_hold(3'd7);

    done = 1;
    summary();
    $finish;
  end
endmodule